// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Unit

This unit keeps the event and run-control state of a network controller. Seven hardware event pulses (init done, transmit done, receive done, memory error, missed frame, collision error, babble) each latch a flag in a 16-bit status register. Software clears a flag by writing 1 to its bit. Two read-only summary bits are derived from the flags. One is an error summary. The other is an interrupt summary, and a separate mask register can keep individual flags out of it. An interrupt-enable bit gates the summary onto an active-low interrupt output.

The same status register carries the run-control bits: init, start, stop and transmit demand, plus the receive-on and transmit-on indications. Writing these bits has defined side effects. A transmit demand produces a one-cycle poll strobe for the buffer manager. Two 16-bit halves of a 32-bit init-block address can be written only while the controller is stopped.

Register select codes on `wr_sel`/`rd_sel`: 0 is the status register, 1 is the low address half, 2 is the high address half and 3 is the mask register. Reads are combinational.

Top module: `nic_irq_status`

## Requirements
- R1: After reset the status register reads 0x0004 (only stop set), the mask register and both address halves read 0, `irq_n` is high and `poll_o` is low.
- R2: A pulse on `evt_i[k]` sets status bit 8+k at the next clock edge. The index k runs 0 init done, 1 transmit done, 2 receive done, 3 memory error, 4 missed frame, 5 collision error, 6 babble. Writing 1 to status bit 8+k clears that flag, and writing 0 leaves it unchanged.
- R3: When an event pulse and a clear (by a 1 written to the flag bit, or by a stop write) reach the same flag in the same cycle, the flag ends up set.
- R4: Status bit 15 reads as the OR of bits 14, 13, 12 and 11. Writes to it have no effect.
- R5: Status bit 7 reads 1 whenever some flag is set whose mask bit is clear. Mask register bits 14, 12, 11, 10, 9 and 8 are writable and mask the flag at the same position. All other mask bits read 0, so the collision flag (bit 13) always contributes.
- R6: Status bit 6 is a plain read/write interrupt enable. `irq_n` is low exactly when bits 7 and 6 are both 1.
- R7: Writing 1 to bit 0 (init) or bit 1 (start) sets that bit and clears stop (bit 2), unless stop is written 1 in the same write. Writing 0 to them has no effect.
- R8: Writing 1 to stop sets stop and, at the same edge, clears init, start, bits 5 and 4, and all seven flags. It wins over start or init written in the same write.
- R9: Bits 5 (receive on) and 4 (transmit on) read 1 from the edge after one at which start is 1 and stop is 0, and are 0 while stopped.
- R10: Writing 1 to bit 3 (transmit demand) makes bit 3 read 1 and `poll_o` high for exactly the cycle after the write. Both are 0 afterwards.
- R11: Writes to the address halves (select 1 low, select 2 high) take effect only while stop is 1. `base_addr_o` is {high, low}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 16 | Read data of the selected register |
| evt_i | input | 7 | One-cycle event pulses, index k sets status bit 8+k |
| irq_n | output | 1 | Active-low interrupt output |
| poll_o | output | 1 | One-cycle transmit poll strobe |
| base_addr_o | output | 32 | Init-block address |

## Verification
Flags, control bits, the mask and the address halves change at the first clock edge after the write or pulse. The summary bits and `irq_n` follow combinationally from that registered state. The receive/transmit-on bits appear one edge later, and the transmit demand bit and poll strobe drop one edge after they rise. The bench drives every stimulus on a falling edge and samples at the following falling edge, or the one after for the delayed results. It keeps a cycle-level model of the register state and compares the full status word each time. It sweeps all 64 mask settings against all seven events with the interrupt enable set.

// File: rtl/irqc_pkg.sv
// Package: shared register selects and field positions of the status unit.
// Assumes a 16-bit register view with flags occupying bits 14..8.
package irqc_pkg;
    localparam int REG_W    = 16;
    localparam int NUM_EVT  = 7;
    localparam int FLAG_LSB = 8;
    localparam int SEL_W    = 2;

    localparam logic [SEL_W-1:0] SEL_STAT = 2'd0;
    localparam logic [SEL_W-1:0] SEL_ALO  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_AHI  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_MASK = 2'd3;

    // Collision error (event index 5) has no mask bit.
    localparam logic [NUM_EVT-1:0] MASKABLE = 7'b101_1111;
    // Error events: memory error, missed frame, collision, babble.
    localparam logic [NUM_EVT-1:0] ERR_SET  = 7'b111_1000;

    // Control bit positions in the status register.
    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TDMD = 3;
    localparam int B_IEN  = 6;
endpackage

// File: rtl/irqc_flags.sv
// Event flag bank: each flag is set by a hardware pulse and cleared by a
// write-1 or a stop write. A set pulse wins over any clear in the same cycle.
// Assumes evt_i pulses are synchronous to clk.
module irqc_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    // Per-flag update: keep unless cleared, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | evt_i;
    end

    assign flags_o = flags_q;

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~evt_i) != '0) |=> ((flags_q & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/irqc_runctl.sv
// Run-control bits: init, start, stop, interrupt enable, transmit demand and
// the receive/transmit-on state. Assumes wr_i is a status-register write.
module irqc_runctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic d_init,
    input  logic d_strt,
    input  logic d_stop,
    input  logic d_tdmd,
    input  logic d_ien,
    output logic init_o,
    output logic strt_o,
    output logic stop_o,
    output logic tdmd_o,
    output logic ien_o,
    output logic on_o,
    output logic stop_wr_o
);
    logic init_q, strt_q, stop_q, tdmd_q, ien_q, on_q;
    logic stop_wr, go_wr;

    assign stop_wr = wr_i & d_stop;
    assign go_wr   = wr_i & (d_init | d_strt);

    // Stop, start and init with stop taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b1;
            strt_q <= 1'b0;
            init_q <= 1'b0;
        end else if (stop_wr) begin
            stop_q <= 1'b1;
            strt_q <= 1'b0;
            init_q <= 1'b0;
        end else if (go_wr) begin
            stop_q <= 1'b0;
            if (d_strt) strt_q <= 1'b1;
            if (d_init) init_q <= 1'b1;
        end
    end

    // Running indication follows start one edge later, cleared by stop.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_wr) on_q <= 1'b0;
        else                   on_q <= strt_q & ~stop_q;
    end

    // Interrupt enable and self-clearing transmit demand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            tdmd_q <= 1'b0;
        end else begin
            if (wr_i) ien_q <= d_ien;
            tdmd_q <= wr_i & d_tdmd;
        end
    end

    assign init_o    = init_q;
    assign strt_o    = strt_q;
    assign stop_o    = stop_q;
    assign tdmd_o    = tdmd_q;
    assign ien_o     = ien_q;
    assign on_o      = on_q;
    assign stop_wr_o = stop_wr;

    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (stop_q && !strt_q && !init_q && !on_q));

    assert_poll_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tdmd_q |=> !tdmd_q || $past(wr_i && d_tdmd));

    assert_on_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        on_q |-> !stop_q);

    assert_go_clears_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && !d_stop) |=> !stop_q);
endmodule

// File: rtl/irqc_addr.sv
// Init-block address halves, writable only while the controller is stopped.
// Assumes sel codes 1 (low half) and 2 (high half).
module irqc_addr #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              stop_i,
    input  logic [HALF_W-1:0] d_i,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o
);
    logic [HALF_W-1:0] lo_q, hi_q;

    // Locked update of both halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (stop_i) begin
            if (wr_lo) lo_q <= d_i;
            if (wr_hi) hi_q <= d_i;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    assert_addr_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_i && (wr_lo || wr_hi)) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/nic_irq_status.sv
// Top: status/mask register file of a network controller with an active-low
// interrupt output and a transmit poll strobe. Assumes single-cycle writes and
// combinational reads; event pulses come from the DMA/MAC side.
module nic_irq_status
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               irq_n,
    output logic               poll_o,
    output logic [ADDR_W-1:0]  base_addr_o
);
    localparam int HALF_W = ADDR_W / 2;

    logic               wr_stat, wr_mask, stop_wr;
    logic               init_b, strt_b, stop_b, tdmd_b, ien_b, on_b;
    logic [NUM_EVT-1:0] flags, clr, mask_q;
    logic               err_sum, int_sum;
    logic [HALF_W-1:0]  alo, ahi;
    logic [REG_W-1:0]   stat_word;
    logic               unused_bits;

    assign wr_stat     = wr_en && (wr_sel == SEL_STAT);
    assign wr_mask     = wr_en && (wr_sel == SEL_MASK);
    assign unused_bits = ^{wr_data[15], wr_data[7], wr_data[5:4]};

    irqc_runctl u_run (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_stat),
        .d_init(wr_data[B_INIT]), .d_strt(wr_data[B_STRT]),
        .d_stop(wr_data[B_STOP]), .d_tdmd(wr_data[B_TDMD]),
        .d_ien(wr_data[B_IEN]),
        .init_o(init_b), .strt_o(strt_b), .stop_o(stop_b), .tdmd_o(tdmd_b),
        .ien_o(ien_b), .on_o(on_b), .stop_wr_o(stop_wr)
    );

    // Clear vector: written ones, or everything on a stop write.
    assign clr = stop_wr ? {NUM_EVT{1'b1}}
                         : (wr_stat ? wr_data[FLAG_LSB +: NUM_EVT] : '0);

    irqc_flags #(.N(NUM_EVT)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr), .flags_o(flags)
    );

    irqc_addr #(.HALF_W(HALF_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_en && (wr_sel == SEL_ALO)),
        .wr_hi(wr_en && (wr_sel == SEL_AHI)),
        .stop_i(stop_b), .d_i(wr_data[HALF_W-1:0]),
        .lo_o(alo), .hi_o(ahi)
    );

    // Mask register, only maskable positions are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wr_data[FLAG_LSB +: NUM_EVT] & MASKABLE;
    end

    // Summary bits and interrupt output.
    assign err_sum = |(flags & ERR_SET);
    assign int_sum = |(flags & ~mask_q);
    assign irq_n   = ~(int_sum & ien_b);
    assign poll_o  = tdmd_b;
    assign base_addr_o = {ahi, alo};

    assign stat_word = {err_sum, flags, int_sum, ien_b, on_b, on_b,
                        tdmd_b, stop_b, strt_b, init_b};

    // Read multiplexer.
    always_comb begin
        case (rd_sel)
            SEL_STAT: rd_data = stat_word;
            SEL_ALO:  rd_data = alo;
            SEL_AHI:  rd_data = ahi;
            default:  rd_data = {1'b0, mask_q, {FLAG_LSB{1'b0}}};
        endcase
    end

    assert_cerr_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[5] && ien_b) |-> !irq_n);

    assert_irq_needs_ien_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (ien_b && (flags != '0)));

    assert_stop_flushes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> ((flags & ~$past(evt_i)) == '0));
endmodule

// File: tb/nic_irq_status_tb_top.sv
// Bench: cycle-level model of the status unit, sweeps events, masks and
// control-bit side effects; drives on falling edges, samples on falling edges.
module nic_irq_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic [6:0]  evt_i = '0;
    logic        irq_n, poll_o;
    logic [31:0] base_addr_o;

    int total = 0;
    int fails = 0;

    // model state
    logic [6:0]  m_flags = '0, m_mask = '0;
    logic        m_ien = 0, m_init = 0, m_strt = 0, m_stop = 1, m_on = 0, m_tdmd = 0;
    logic [15:0] m_lo = '0, m_hi = '0;

    always #5 clk = ~clk;

    nic_irq_status dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .evt_i(evt_i), .irq_n(irq_n), .poll_o(poll_o), .base_addr_o(base_addr_o)
    );

    function automatic logic m_int();
        return |(m_flags & ~(m_mask & 7'b101_1111));
    endfunction

    function automatic logic [15:0] exp_stat();
        return {|m_flags[6:3], m_flags, m_int(), m_ien, m_on, m_on,
                m_tdmd, m_stop, m_strt, m_init};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    // One cycle: drive at falling edge, model the edge, return at next falling edge.
    task automatic step(input logic we, input logic [1:0] s, input logic [15:0] d,
                        input logic [6:0] ev);
        logic sw, gw, new_on;
        wr_en = we; wr_sel = s; wr_data = d; evt_i = ev;
        sw = we && s == 2'd0 && d[2];
        gw = we && s == 2'd0 && (d[0] || d[1]);
        new_on = sw ? 1'b0 : (m_strt & ~m_stop);
        if (we && s == 2'd1 && m_stop) m_lo = d;
        if (we && s == 2'd2 && m_stop) m_hi = d;
        if (we && s == 2'd3) m_mask = d[14:8] & 7'b101_1111;
        if (sw) m_flags = ev;
        else if (we && s == 2'd0) m_flags = (m_flags & ~d[14:8]) | ev;
        else m_flags = m_flags | ev;
        if (we && s == 2'd0) m_ien = d[6];
        m_tdmd = we && s == 2'd0 && d[3];
        if (sw) begin m_stop = 1; m_strt = 0; m_init = 0; end
        else if (gw) begin m_stop = 0; if (d[1]) m_strt = 1; if (d[0]) m_init = 1; end
        m_on = new_on;
        @(negedge clk);
        wr_en = 0; evt_i = '0;
    endtask

    task automatic chk_stat(input string tag);
        logic [15:0] v;
        rd(2'd0, v);
        chk({tag, " status"}, {16'h0, v}, {16'h0, exp_stat()});
        chk({tag, " irq_n"}, {31'h0, irq_n}, {31'h0, ~(m_int() & m_ien)});
        chk({tag, " poll"}, {31'h0, poll_o}, {31'h0, m_tdmd});
    endtask

    initial begin
        #1000000;
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] v;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk_stat("R1 reset");
        chk("R1 reset status word", {16'h0, exp_stat()}, 32'h0004);
        rd(2'd3, v); chk("R1 mask", {16'h0, v}, 32'h0);
        chk("R1 addr", base_addr_o, 32'h0);

        // R2 / R4: each event sets its bit; write 0 no effect; write 1 clears
        for (int k = 0; k < 7; k++) begin
            step(0, 0, 0, 7'(1 << k));
            chk_stat("R2 set / R4 err");
            chk("R4 err bit", {31'h0, exp_stat()[15]}, {31'h0, (k >= 3)});
            step(1, 0, 16'h0000, 0);
            chk_stat("R2 write0 no effect");
            step(1, 0, 16'(1 << (8 + k)) | 16'h8080, 0);
            chk_stat("R2 clear / R4 readonly");
        end

        // R3: set wins over simultaneous clear
        for (int k = 0; k < 7; k++) begin
            step(0, 0, 0, 7'(1 << k));
            step(1, 0, 16'(1 << (8 + k)), 7'(1 << k));
            chk_stat("R3 set wins");
            step(1, 0, 16'(1 << (8 + k)), 0);
        end

        // R5 / R6: all mask settings against all events, interrupt enabled
        for (int m = 0; m < 64; m++) begin
            logic [6:0] mv;
            mv = {m[5], 1'b1, m[4:0]};
            step(1, 3, {1'b0, mv, 8'h00}, 0);
            rd(2'd3, v);
            chk("R5 mask readback", {16'h0, v}, {16'h0, 1'b0, mv & 7'b101_1111, 8'h00});
            for (int k = 0; k < 7; k++) begin
                step(0, 0, 0, 7'(1 << k));
                if (k == 0) step(1, 0, 16'h0040, 0);
                chk_stat("R5 summary R6 irq");
                step(1, 0, 16'h7F40, 0);
            end
        end
        step(1, 3, 16'h0000, 0);

        // R11: address writable while stopped
        step(1, 1, 16'hBEEF, 0);
        step(1, 2, 16'h1234, 0);
        chk("R11 addr stopped", base_addr_o, {m_hi, m_lo});
        chk("R11 addr value", base_addr_o, 32'h1234BEEF);

        // R7 / R9: start clears stop, running bits one edge later
        step(1, 0, 16'h0042, 0);
        chk_stat("R7 start");
        chk("R9 on not yet", {31'h0, exp_stat()[5]}, 32'h0);
        step(0, 0, 0, 0);
        chk_stat("R9 running");
        chk("R9 on bits", {30'h0, exp_stat()[5:4]}, 32'h3);

        // R11: address locked while running
        step(1, 1, 16'h5555, 0);
        step(1, 2, 16'hAAAA, 0);
        chk("R11 addr locked", base_addr_o, 32'h1234BEEF);

        // R10: transmit demand strobe
        step(1, 0, 16'h0048, 0);
        chk_stat("R10 demand set");
        chk("R10 poll high", {31'h0, poll_o}, 32'h1);
        step(0, 0, 0, 0);
        chk_stat("R10 demand cleared");
        chk("R10 poll low", {31'h0, poll_o}, 32'h0);

        // R8: stop clears flags and control, keeps an event arriving that cycle
        step(0, 0, 0, 7'h7F);
        chk_stat("R8 pre-stop flags");
        step(1, 0, 16'h0044, 0);
        chk_stat("R8 stop clears");
        step(1, 0, 16'h0043, 0);
        chk_stat("R7 init+start");
        step(0, 0, 0, 7'h7F);
        step(1, 0, 16'h0044, 7'h20);
        chk_stat("R8 stop with event R3");
        step(1, 0, 16'h0047, 0);
        chk_stat("R8 stop wins over start");
        chk("R8 stop bit", {31'h0, exp_stat()[2]}, 32'h1);
        step(1, 0, 16'h0041, 0);
        chk_stat("R7 init only");
        step(1, 0, 16'h0040, 0);
        chk_stat("R7 write0 no effect");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule